// File: doc/BRIEF.md
# Fused Multiply-Add NaN Selector

This unit sits in the special-operand path of a fused multiply-add datapath that computes `mul_a * mul_b + addend` without intermediate rounding. When at least one of the three operands is a NaN, the arithmetic result is replaced by a NaN chosen here. The unit decides which input NaN propagates, or whether a generated default NaN is returned instead. It also decides whether the invalid-operation exception fires. The arithmetic itself, rounding, and the invalid case of an infinity-times-zero product with no NaN operand are handled elsewhere in the datapath.

Three operand-priority orderings can be selected at run time. One puts signaling NaNs ahead of quiet ones and checks the addend first. One puts the first multiplicand first and lets an infinity-times-zero product forward the addend. One is a plain fixed order. An override forces the default NaN regardless of the ordering. The same selection logic serves single and double precision. Single-precision operands occupy the low 32 bits of each 64-bit operand port. The unit is purely combinational, so its outputs follow its inputs within the same cycle.

Top module: `fma_nan_select`

## Requirements
- R1: When the operand format is resolved and any of the three operands is a signaling NaN, `flag_invalid` is 1, whichever NaN is returned.
- R2: With `order_sel` = 0 and `prod_inf_zero` = 1, a quiet-NaN addend gives `flag_invalid` = 1 and the default NaN as the result.
- R3: With `order_sel` = 0 and no R2 case, the returned operand is the first that matches this list: signaling addend, signaling `mul_a`, signaling `mul_b`, quiet addend, quiet `mul_a`, and otherwise `mul_b`.
- R4: With `order_sel` = 1 and `prod_inf_zero` = 1, `flag_invalid` is 1 and the addend NaN is returned. No default NaN is generated.
- R5: With `order_sel` = 1 and `prod_inf_zero` = 0, the result is `mul_a` if it is any NaN, otherwise the addend if it is any NaN, otherwise `mul_b`.
- R6: With `order_sel` = 2 or 3, the result is `mul_a` if it is any NaN, otherwise `mul_b` if it is any NaN, otherwise the addend. `prod_inf_zero` does not raise invalid in this ordering.
- R7: With `dflt_nan_en` = 1 and some NaN present, the result is the default NaN. `flag_invalid` is still set exactly as R1 to R4 require.
- R8: When no operand is a NaN, `res_valid` = 0, `flag_invalid` = 0 and `res_nan` = 0.
- R9: A NaN has an all-ones exponent and a nonzero fraction. With `fmt_dbl` = 0, only bits 31:0 are examined: exponent 30:23, fraction 22:0. Bits 63:32 are ignored and are driven to 0 on `res_nan`. With `fmt_dbl` = 1, the exponent is bits 62:52 and the fraction is bits 51:0.
- R10: A returned input NaN keeps its sign and payload and has its quiet bit set. The quiet bit is bit 22 for single precision and bit 51 for double. The bit is 1 for quiet NaNs and 0 for signaling NaNs. The default NaN is 0x7FC00000 for single and 0x7FF8000000000000 for double.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fmt_dbl | input | 1 | 1 selects double-precision operands, 0 single (low 32 bits) |
| order_sel | input | 2 | Priority ordering: 0 signaling-first, 1 multiplicand-first, 2 or 3 fixed |
| dflt_nan_en | input | 1 | Forces the default NaN as the result |
| prod_inf_zero | input | 1 | The product was infinity times zero |
| mul_a | input | 64 | First multiplicand |
| mul_b | input | 64 | Second multiplicand |
| addend | input | 64 | Addend |
| res_valid | output | 1 | At least one operand is a NaN; `res_nan` replaces the arithmetic result |
| res_nan | output | 64 | NaN to return |
| flag_invalid | output | 1 | Invalid-operation exception |

## Verification
The bench targets these corner cases:
- An ordering that checks the signaling class before the operand position. If signaling status were ignored, a quiet addend would win over a signaling multiplicand.
- A signaling NaN that loses the selection. A design that derived invalid from the chosen operand alone would miss the exception.
- The infinity-times-zero case in each ordering. A mix-up would return the default NaN where the addend is due, or drop the exception.
- The default-NaN override. A design that applied it before the selection would lose the exception.
- Format boundaries: NaN-looking upper bits in single mode, single NaN bit patterns read as doubles, and plain infinities. An error here would raise a spurious result or fail to set the quiet bit.

// File: rtl/fma_nan_pkg.sv
// Shared types for the FMA NaN selector.
// Assumes: operands are IEEE binary32 (low half) or binary64 words.
package fma_nan_pkg;

    // Which candidate becomes the result.
    typedef enum logic [1:0] {
        PICK_MA   = 2'd0,
        PICK_MB   = 2'd1,
        PICK_ADD  = 2'd2,
        PICK_DFLT = 2'd3
    } pick_e;

    // Run-time priority ordering.
    typedef enum logic [1:0] {
        ORD_SNAN_FIRST = 2'd0,
        ORD_MA_FIRST   = 2'd1,
        ORD_FIXED      = 2'd2,
        ORD_FIXED_ALT  = 2'd3
    } order_e;

    // NaN classification of one operand.
    typedef struct packed {
        logic quiet;
        logic signaling;
    } nan_kind_t;

endpackage

// File: rtl/fma_nan_classify.sv
// Classifies one operand as quiet NaN, signaling NaN or neither, and
// produces its quieted form. Assumes that single-precision values occupy
// the low SP_W bits and that bits above them are don't-care.
module fma_nan_classify
    import fma_nan_pkg::*;
#(
    parameter int SP_EXP_W  = 8,
    parameter int SP_FRAC_W = 23,
    parameter int DP_EXP_W  = 11,
    parameter int DP_FRAC_W = 52,
    localparam int SP_W = 1 + SP_EXP_W + SP_FRAC_W,
    localparam int DP_W = 1 + DP_EXP_W + DP_FRAC_W
) (
    input  logic [DP_W-1:0] op_i,
    input  logic            dbl_i,
    output nan_kind_t       kind_o,
    output logic [DP_W-1:0] quiet_o
);

    localparam logic [SP_W-1:0] SP_QMASK = SP_W'(1) << (SP_FRAC_W - 1);
    localparam logic [DP_W-1:0] DP_QMASK = DP_W'(1) << (DP_FRAC_W - 1);

    logic [SP_EXP_W-1:0]  sp_exp;
    logic [SP_FRAC_W-1:0] sp_frac;
    logic [DP_EXP_W-1:0]  dp_exp;
    logic [DP_FRAC_W-1:0] dp_frac;
    logic                 is_nan;
    logic                 qbit;

    // Split the operand into fields for the selected format.
    always_comb begin
        sp_exp  = op_i[SP_W-2 -: SP_EXP_W];
        sp_frac = op_i[SP_FRAC_W-1:0];
        dp_exp  = op_i[DP_W-2 -: DP_EXP_W];
        dp_frac = op_i[DP_FRAC_W-1:0];
    end

    // Classify and quiet: all-ones exponent, nonzero fraction, MSB of fraction = quiet.
    always_comb begin
        if (dbl_i) begin
            is_nan  = (&dp_exp) && (|dp_frac);
            qbit    = dp_frac[DP_FRAC_W-1];
            quiet_o = op_i | DP_QMASK;
        end else begin
            is_nan  = (&sp_exp) && (|sp_frac);
            qbit    = sp_frac[SP_FRAC_W-1];
            quiet_o = {{(DP_W-SP_W){1'b0}}, op_i[SP_W-1:0] | SP_QMASK};
        end
        kind_o.quiet     = is_nan && qbit;
        kind_o.signaling = is_nan && !qbit;
    end

    // A quiet NaN is unchanged by quieting (within its format).
    always_comb begin
        if (kind_o.quiet) begin
            assert_quiet_unchanged_R10: assert (dbl_i ? (quiet_o == op_i)
                                         : (quiet_o[SP_W-1:0] == op_i[SP_W-1:0]));
        end
    end

endmodule

// File: rtl/fma_nan_priority.sv
// Chooses which candidate NaN propagates under the selected ordering and
// reports whether the choice itself raises invalid. Assumes at least one
// operand is a NaN whenever the result is used.
module fma_nan_priority
    import fma_nan_pkg::*;
(
    input  nan_kind_t k_ma_i,
    input  nan_kind_t k_mb_i,
    input  nan_kind_t k_add_i,
    input  logic      inf_zero_i,
    input  order_e    order_i,
    output pick_e     pick_o,
    output logic      sel_inv_o
);

    logic ma_any;
    logic mb_any;
    logic add_any;

    // Any-kind NaN flags per operand.
    always_comb begin
        ma_any  = k_ma_i.quiet  || k_ma_i.signaling;
        mb_any  = k_mb_i.quiet  || k_mb_i.signaling;
        add_any = k_add_i.quiet || k_add_i.signaling;
    end

    // Priority resolution for each ordering.
    always_comb begin
        pick_o    = PICK_ADD;
        sel_inv_o = 1'b0;
        case (order_i)
            ORD_SNAN_FIRST: begin
                if (inf_zero_i && k_add_i.quiet) begin
                    pick_o    = PICK_DFLT;
                    sel_inv_o = 1'b1;
                end else if (k_add_i.signaling) pick_o = PICK_ADD;
                else if (k_ma_i.signaling)      pick_o = PICK_MA;
                else if (k_mb_i.signaling)      pick_o = PICK_MB;
                else if (k_add_i.quiet)         pick_o = PICK_ADD;
                else if (k_ma_i.quiet)          pick_o = PICK_MA;
                else                            pick_o = PICK_MB;
            end
            ORD_MA_FIRST: begin
                if (inf_zero_i) begin
                    pick_o    = PICK_ADD;
                    sel_inv_o = 1'b1;
                end else if (ma_any)  pick_o = PICK_MA;
                else if (add_any)     pick_o = PICK_ADD;
                else                  pick_o = PICK_MB;
            end
            default: begin
                if (ma_any)       pick_o = PICK_MA;
                else if (mb_any)  pick_o = PICK_MB;
                else              pick_o = PICK_ADD;
            end
        endcase
    end

    // Generated default NaN only arises from the signaling-first inf*zero case.
    always_comb begin
        if (pick_o == PICK_DFLT) begin
            assert_dflt_origin_R2: assert (order_i == ORD_SNAN_FIRST && inf_zero_i && k_add_i.quiet);
        end
        if (order_i == ORD_FIXED || order_i == ORD_FIXED_ALT) begin
            assert_fixed_no_sel_inv_R6: assert (!sel_inv_o);
        end
    end

endmodule

// File: rtl/fma_nan_mux.sv
// Drives the final result word: the picked quieted candidate, the default
// NaN of the active format, or zero when no NaN is present.
module fma_nan_mux
    import fma_nan_pkg::*;
#(
    parameter int SP_W = 32,
    parameter int DP_W = 64,
    parameter int NUM_OPS = 3,
    parameter logic [SP_W-1:0] DFLT_SP = 32'h7FC0_0000,
    parameter logic [DP_W-1:0] DFLT_DP = 64'h7FF8_0000_0000_0000
) (
    input  logic [NUM_OPS-1:0][DP_W-1:0] cand_i,
    input  pick_e                        pick_i,
    input  logic                         dflt_en_i,
    input  logic                         dbl_i,
    input  logic                         valid_i,
    output logic [DP_W-1:0]              res_o
);

    logic [DP_W-1:0] dflt_word;

    // Default NaN of the active format.
    always_comb begin
        dflt_word = dbl_i ? DFLT_DP : {{(DP_W-SP_W){1'b0}}, DFLT_SP};
    end

    // Result selection.
    always_comb begin
        if (!valid_i) begin
            res_o = '0;
        end else if (dflt_en_i) begin
            res_o = dflt_word;
        end else begin
            case (pick_i)
                PICK_MA:  res_o = cand_i[0];
                PICK_MB:  res_o = cand_i[1];
                PICK_ADD: res_o = cand_i[2];
                default:  res_o = dflt_word;
            endcase
        end
    end

endmodule

// File: rtl/fma_nan_select.sv
// Top of the FMA NaN selector. Classifies the three operands, resolves the
// propagated NaN and the invalid flag. Purely combinational; assumes the
// caller only uses res_nan when res_valid is 1.
module fma_nan_select
    import fma_nan_pkg::*;
#(
    parameter int SP_EXP_W  = 8,
    parameter int SP_FRAC_W = 23,
    parameter int DP_EXP_W  = 11,
    parameter int DP_FRAC_W = 52,
    localparam int SP_W = 1 + SP_EXP_W + SP_FRAC_W,
    localparam int DP_W = 1 + DP_EXP_W + DP_FRAC_W,
    parameter logic [SP_W-1:0] DFLT_SP = 32'h7FC0_0000,
    parameter logic [DP_W-1:0] DFLT_DP = 64'h7FF8_0000_0000_0000
) (
    input  logic            fmt_dbl,
    input  logic [1:0]      order_sel,
    input  logic            dflt_nan_en,
    input  logic            prod_inf_zero,
    input  logic [DP_W-1:0] mul_a,
    input  logic [DP_W-1:0] mul_b,
    input  logic [DP_W-1:0] addend,
    output logic            res_valid,
    output logic [DP_W-1:0] res_nan,
    output logic            flag_invalid
);

    localparam int NUM_OPS = 3;

    logic [NUM_OPS-1:0][DP_W-1:0] ops;
    logic [NUM_OPS-1:0][DP_W-1:0] quieted;
    nan_kind_t [NUM_OPS-1:0]      kinds;
    logic                         any_snan;
    logic                         any_nan;
    logic                         sel_inv;
    pick_e                        pick;

    // Operand order: 0 = mul_a, 1 = mul_b, 2 = addend.
    assign ops[0] = mul_a;
    assign ops[1] = mul_b;
    assign ops[2] = addend;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_cls
        fma_nan_classify #(
            .SP_EXP_W (SP_EXP_W),
            .SP_FRAC_W(SP_FRAC_W),
            .DP_EXP_W (DP_EXP_W),
            .DP_FRAC_W(DP_FRAC_W)
        ) u_cls (
            .op_i   (ops[g]),
            .dbl_i  (fmt_dbl),
            .kind_o (kinds[g]),
            .quiet_o(quieted[g])
        );
    end

    // Reduce per-operand classes to summary flags.
    always_comb begin
        any_snan = 1'b0;
        any_nan  = 1'b0;
        for (int i = 0; i < NUM_OPS; i++) begin
            any_snan = any_snan | kinds[i].signaling;
            any_nan  = any_nan | kinds[i].signaling | kinds[i].quiet;
        end
    end

    fma_nan_priority u_prio (
        .k_ma_i    (kinds[0]),
        .k_mb_i    (kinds[1]),
        .k_add_i   (kinds[2]),
        .inf_zero_i(prod_inf_zero),
        .order_i   (order_e'(order_sel)),
        .pick_o    (pick),
        .sel_inv_o (sel_inv)
    );

    fma_nan_mux #(
        .SP_W   (SP_W),
        .DP_W   (DP_W),
        .NUM_OPS(NUM_OPS),
        .DFLT_SP(DFLT_SP),
        .DFLT_DP(DFLT_DP)
    ) u_mux (
        .cand_i   (quieted),
        .pick_i   (pick),
        .dflt_en_i(dflt_nan_en),
        .dbl_i    (fmt_dbl),
        .valid_i  (any_nan),
        .res_o    (res_nan)
    );

    // Output flags: valid on any NaN; invalid from signaling inputs or the selection rule.
    always_comb begin
        res_valid    = any_nan;
        flag_invalid = any_nan && (any_snan || sel_inv);
    end

    // Output-level checks.
    always_comb begin
        if (any_snan) begin
            assert_snan_invalid_R1: assert (flag_invalid);
        end
        if (!res_valid) begin
            assert_idle_zero_R8: assert (res_nan == '0 && !flag_invalid);
        end
        if (!fmt_dbl) begin
            assert_single_upper_zero_R9: assert (res_nan[DP_W-1:SP_W] == '0);
        end
        if (res_valid && fmt_dbl) begin
            assert_dp_quiet_nan_R10: assert ((&res_nan[DP_W-2 -: DP_EXP_W]) && res_nan[DP_FRAC_W-1]);
        end
        if (res_valid && !fmt_dbl) begin
            assert_sp_quiet_nan_R10: assert ((&res_nan[SP_W-2 -: SP_EXP_W]) && res_nan[SP_FRAC_W-1]);
        end
        if (res_valid && dflt_nan_en) begin
            assert_dflt_override_R7: assert (fmt_dbl ? (res_nan == DFLT_DP)
                                      : (res_nan[SP_W-1:0] == DFLT_SP));
        end
    end

endmodule

// File: tb/fma_nan_select_tb_top.sv
// Self-checking bench for fma_nan_select: vector table then directed cases.
module fma_nan_select_tb_top;

    logic        clk = 1'b0;
    logic        fmt_dbl;
    logic [1:0]  order_sel;
    logic        dflt_nan_en;
    logic        prod_inf_zero;
    logic [63:0] mul_a, mul_b, addend;
    logic        res_valid;
    logic [63:0] res_nan;
    logic        flag_invalid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    fma_nan_select dut_i (
        .fmt_dbl      (fmt_dbl),
        .order_sel    (order_sel),
        .dflt_nan_en  (dflt_nan_en),
        .prod_inf_zero(prod_inf_zero),
        .mul_a        (mul_a),
        .mul_b        (mul_b),
        .addend       (addend),
        .res_valid    (res_valid),
        .res_nan      (res_nan),
        .flag_invalid (flag_invalid)
    );

    // Single-precision operands (low half).
    localparam logic [63:0] QA  = 64'h7FC0_0001, SA = 64'h7F80_0002, SA_Q = 64'h7FC0_0002;
    localparam logic [63:0] QB  = 64'hFFC0_0003, SB = 64'hFF80_0004, SB_Q = 64'hFFC0_0004;
    localparam logic [63:0] QC  = 64'h7FC0_0005, SC = 64'h7F80_0006, SC_Q = 64'h7FC0_0006;
    localparam logic [63:0] ONE = 64'h3F80_0000, INF = 64'h7F80_0000, ZRO = 64'h0;
    localparam logic [63:0] DN  = 64'h7FC0_0000;
    // Double-precision operands.
    localparam logic [63:0] DQA = 64'h7FF8_0000_0000_0001;
    localparam logic [63:0] DSB = 64'hFFF0_0000_0000_0004, DSB_Q = 64'hFFF8_0000_0000_0004;
    localparam logic [63:0] DQC = 64'h7FF8_0000_0000_0005;
    localparam logic [63:0] DONE = 64'h3FF0_0000_0000_0000, DINF = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] DDN = 64'h7FF8_0000_0000_0000;

    typedef struct packed {
        logic [1:0]  ord;
        logic        dflt;
        logic        dbl;
        logic        iz;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] c;
        logic        ev;
        logic        ei;
        logic [63:0] er;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VECS [NV] = '{
        '{2'd0,1'b0,1'b0,1'b0, SA,  SB,  QC,  1'b1,1'b1, SA_Q}, // 0  R3 signaling a beats quiet addend
        '{2'd0,1'b0,1'b0,1'b0, SA,  ONE, SC,  1'b1,1'b1, SC_Q}, // 1  R3 signaling addend first
        '{2'd0,1'b0,1'b0,1'b0, ONE, SB,  QC,  1'b1,1'b1, SB_Q}, // 2  R3 signaling b beats quiet addend
        '{2'd0,1'b0,1'b0,1'b0, QA,  QB,  QC,  1'b1,1'b0, QC},   // 3  R3 quiet addend first
        '{2'd0,1'b0,1'b0,1'b0, QA,  QB,  ONE, 1'b1,1'b0, QA},   // 4  R3 quiet a over b
        '{2'd0,1'b0,1'b0,1'b0, ONE, QB,  ONE, 1'b1,1'b0, QB},   // 5  R3 fallback b
        '{2'd0,1'b0,1'b0,1'b1, INF, ZRO, QC,  1'b1,1'b1, DN},   // 6  R2 inf*zero quiet addend
        '{2'd0,1'b0,1'b0,1'b1, INF, ZRO, SC,  1'b1,1'b1, SC_Q}, // 7  R2 signaling addend not defaulted
        '{2'd1,1'b0,1'b0,1'b0, QA,  SB,  SC,  1'b1,1'b1, QA},   // 8  R5 R1 a wins, invalid from losers
        '{2'd1,1'b0,1'b0,1'b0, ONE, SB,  QC,  1'b1,1'b1, QC},   // 9  R5 addend before b
        '{2'd1,1'b0,1'b0,1'b0, ONE, QB,  ONE, 1'b1,1'b0, QB},   // 10 R5 fallback b
        '{2'd1,1'b0,1'b0,1'b1, ZRO, INF, QC,  1'b1,1'b1, QC},   // 11 R4 inf*zero forwards addend
        '{2'd2,1'b0,1'b0,1'b0, ONE, QB,  SC,  1'b1,1'b1, QB},   // 12 R6 R1 b before addend
        '{2'd2,1'b0,1'b0,1'b0, SA,  QB,  QC,  1'b1,1'b1, SA_Q}, // 13 R6 R10 a first, quieted
        '{2'd2,1'b0,1'b0,1'b0, ONE, ONE, QC,  1'b1,1'b0, QC},   // 14 R6 addend last
        '{2'd2,1'b0,1'b0,1'b1, INF, ZRO, QC,  1'b1,1'b0, QC},   // 15 R6 inf*zero no invalid
        '{2'd0,1'b1,1'b0,1'b0, ONE, ONE, SC,  1'b1,1'b1, DN},   // 16 R7 override keeps snan invalid
        '{2'd0,1'b1,1'b0,1'b1, INF, ZRO, QC,  1'b1,1'b1, DN},   // 17 R7 override keeps selection invalid
        '{2'd2,1'b1,1'b0,1'b0, QA,  ONE, ONE, 1'b1,1'b0, DN},   // 18 R7 override quiet only
        '{2'd3,1'b0,1'b0,1'b0, ONE, QB,  QC,  1'b1,1'b0, QB},   // 19 R6 ordering 3 as fixed
        '{2'd0,1'b0,1'b0,1'b0, ONE, ONE, ONE, 1'b0,1'b0, ZRO},  // 20 R8 no NaN
        '{2'd0,1'b0,1'b1,1'b0, DQA, DSB, DQC, 1'b1,1'b1, DSB_Q},// 21 R3 R10 double signaling b
        '{2'd1,1'b0,1'b1,1'b0, DONE,DSB, DQC, 1'b1,1'b1, DQC},  // 22 R5 double
        '{2'd0,1'b0,1'b1,1'b1, DINF,ZRO, DQC, 1'b1,1'b1, DDN},  // 23 R2 double default NaN
        '{2'd2,1'b1,1'b1,1'b0, DQA, DONE,DONE,1'b1,1'b0, DDN},  // 24 R7 double default NaN
        '{2'd2,1'b0,1'b0,1'b0, 64'h7FF8_0000_3F80_0000, 64'hFFF0_0001_3F80_0000, ONE,
                                                          1'b0,1'b0, ZRO},  // 25 R9 upper bits ignored
        '{2'd2,1'b0,1'b1,1'b0, QA,  ONE,ONE,  1'b0,1'b0, ZRO},  // 26 R9 single NaN bits not a double NaN
        '{2'd2,1'b0,1'b0,1'b0, INF, ONE,ONE,  1'b0,1'b0, ZRO},  // 27 R9 infinity is not NaN
        '{2'd1,1'b0,1'b0,1'b0, 64'hFFFF_FFFF_7F80_0002, ONE, ONE, 1'b1,1'b1, SA_Q} // 28 R9 R10 upper zeroed
    };

    function automatic string req_of(int i);
        case (i)
            0,1,2,3,4,5,21:     return "R3";
            6,7,23:             return "R2";
            8:                  return "R5/R1";
            9,10,22:            return "R5";
            11:                 return "R4";
            12:                 return "R6/R1";
            13,14,15,19:        return "R6";
            16,17,18,24:        return "R7";
            20:                 return "R8";
            default:            return "R9";
        endcase
    endfunction

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(vec_t v);
        order_sel     = v.ord;
        dflt_nan_en   = v.dflt;
        fmt_dbl       = v.dbl;
        prod_inf_zero = v.iz;
        mul_a         = v.a;
        mul_b         = v.b;
        addend        = v.c;
    endtask

    initial begin
        drive('0);
        @(negedge clk);
        // Idle state with all-zero inputs: R8.
        chk("R8", "idle valid", 64'(res_valid), 64'd0);
        chk("R8", "idle invalid", 64'(flag_invalid), 64'd0);
        chk("R8", "idle result", res_nan, 64'd0);

        for (int i = 0; i < NV; i++) begin
            @(posedge clk);
            drive(VECS[i]);
            @(negedge clk);
            chk(req_of(i), $sformatf("vec%0d valid", i), 64'(res_valid), 64'(VECS[i].ev));
            chk(req_of(i), $sformatf("vec%0d invalid", i), 64'(flag_invalid), 64'(VECS[i].ei));
            chk(req_of(i), $sformatf("vec%0d result", i), res_nan, VECS[i].er);
        end

        // Directed R1: all three signaling under fixed ordering, a chosen.
        @(posedge clk);
        drive('{2'd2,1'b0,1'b0,1'b0, SA, SB, SC, 1'b1,1'b1, SA_Q});
        @(negedge clk);
        chk("R1", "triple snan invalid", 64'(flag_invalid), 64'd1);
        chk("R10", "triple snan result", res_nan, SA_Q);

        // Directed R4: inf*zero with signaling addend in multiplicand-first ordering.
        @(posedge clk);
        drive('{2'd1,1'b0,1'b0,1'b1, INF, ZRO, SC, 1'b1,1'b1, SC_Q});
        @(negedge clk);
        chk("R4", "inf*zero snan addend", res_nan, SC_Q);
        chk("R4", "inf*zero snan invalid", 64'(flag_invalid), 64'd1);

        // Directed R8: return to no-NaN inputs clears outputs.
        @(posedge clk);
        drive('{2'd0,1'b1,1'b1,1'b1, DONE, DONE, DONE, 1'b0,1'b0, ZRO});
        @(negedge clk);
        chk("R8", "no NaN dbl valid", 64'(res_valid), 64'd0);
        chk("R8", "no NaN dbl invalid", 64'(flag_invalid), 64'd0);
        chk("R8", "no NaN dbl result", res_nan, 64'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule